// File: doc/BRIEF.md
# Interrupt entry sequencer

This block carries out the hardware part of entering an interrupt service routine on a 16-bit processor with segmented memory. A host core signals when it sits between instructions (`at_boundary`). The block then picks one pending request from three sources: a non-maskable line, a maskable level request, and a software request that carries its own type number. It takes a snapshot of the flag, code-segment, instruction-pointer, stack-segment and stack-pointer values the host supplies. It then stores three words on a stack that grows toward lower addresses, clears the interrupt-enable flag and then the trap flag, and fetches the new instruction pointer and code segment from the vector table. When it finishes, it hands the updated values back to the host.

The sequence is a single state machine that runs through these states:
- `ST_IDLE`: waits for a grant.
- `ST_PUSH_FL`: writes the flags.
- `ST_CLR_IF` and `ST_CLR_TF`: each takes one cycle and clears one flag.
- `ST_PUSH_CS` and `ST_PUSH_IP`: write the code segment, then the instruction pointer.
- `ST_RD_IP` and `ST_RD_CS`: read the vector, instruction pointer first.
- `ST_DONE`: one cycle.

The transitions are as follows:
- `ST_IDLE` to `ST_PUSH_FL` on a grant.
- Each memory state moves on when `mem_ack` arrives: `ST_PUSH_FL` to `ST_CLR_IF`, `ST_PUSH_CS` to `ST_PUSH_IP`, `ST_PUSH_IP` to `ST_RD_IP`, `ST_RD_IP` to `ST_RD_CS`, and `ST_RD_CS` to `ST_DONE`.
- `ST_CLR_IF` to `ST_CLR_TF`, `ST_CLR_TF` to `ST_PUSH_CS`, and `ST_DONE` to `ST_IDLE` happen unconditionally.

Memory is reached through a word-wide request port. The block holds a request until it is acknowledged.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_req` and `src_grant` are 0, and `flags_out`, `cs_out`, `ip_out` and `sp_out` read 0.
- R2: A grant is a one-cycle one-hot pulse on `src_grant`: bit 0 for the non-maskable source, bit 1 for software, bit 2 for the maskable source. It is issued only while idle with `at_boundary` high. When several sources are pending, the non-maskable source wins over software, and software wins over the maskable source.
- R3: The maskable request is granted only when bit 9 of `flags_in` (interrupt enable) is 1. Otherwise it is ignored and no sequence starts.
- R4: A rising edge on `nmi_in` stays pending, even across a running sequence, until its own sequence is granted. A level held high does not cause a second grant. Its type number is 2.
- R5: Exactly three writes occur, in this order: the captured flags to SS*16+SP-2, CS to SS*16+SP-4, and IP to SS*16+SP-6. At the end, `sp_out` equals SP-6.
- R6: Bit 9 is cleared in one cycle and bit 8 (trap) in the next cycle, both after the flag write. The final `flags_out` equals the captured flags with bits 9 and 8 cleared.
- R7: Two reads follow the writes: the new IP from type*4, then the new CS from type*4+2. Both addresses lie in 00000h to 003FFh.
- R8: `done` is a one-cycle pulse. It occurs once `cs_out` and `ip_out` hold the two words read from the vector.
- R9: While `mem_req` waits for `mem_ack`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged, for any number of wait cycles.
- R10: Stack addresses are formed modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| at_boundary | input | 1 | Host is between instructions |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| intr_in | input | 1 | Maskable request, level sensitive |
| intr_type | input | 8 | Type number of the maskable request |
| sw_req | input | 1 | Software interrupt request, held until granted |
| sw_type | input | 8 | Type number of the software request |
| flags_in | input | 16 | Current flag word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| src_grant | output | 3 | One-hot grant pulse |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Sequence finished |
| flags_out | output | 16 | Flag word as modified |
| cs_out | output | 16 | Code segment, the vector value at the end |
| ip_out | output | 16 | Instruction pointer, the vector value at the end |
| sp_out | output | 16 | Stack pointer after the writes |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completes at this clock edge |

## Verification
The sequence is first run with a single maskable request at an ordinary stack location with zero-wait memory. This establishes the write order, the captured flag value and the vector fetch. Next, all three sources are raised at one boundary and then served back to back. The grant order this produces separates a correct priority from a swapped one. It also shows whether the held maskable level survives the two sequences ahead of it. A non-maskable edge that arrives mid-sequence, followed by a long held level, tells edge latching apart from level sensing and from a lost request. A stack pointer near zero with the top segment, together with vector types 0 and 255 under wait states, exercises address wrap, the table limits and request stability.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_CLR_IF,
        ST_CLR_TF,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_RD_IP,
        ST_RD_CS,
        ST_DONE
    } seq_state_e;

    // grant vector bit positions, highest priority first
    localparam int GNT_NMI  = 0;
    localparam int GNT_SW   = 1;
    localparam int GNT_INTR = 2;
    localparam int GNT_W    = 3;

endpackage

// File: rtl/irq_src_arb.sv
module irq_src_arb
    import irq_seq_pkg::*;
#(
    parameter int TYPE_W   = 8,
    parameter int NMI_TYPE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic              intr_in,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic              sw_req,
    input  logic [TYPE_W-1:0] sw_type,
    input  logic              if_flag,
    input  logic              can_take,
    output logic [GNT_W-1:0]  grant,
    output logic [TYPE_W-1:0] sel_type,
    output logic              nmi_pend
);

    logic nmi_prev_q;
    logic nmi_pend_q;
    logic nmi_rise;

    assign nmi_rise = nmi_in & ~nmi_prev_q;
    assign nmi_pend = nmi_pend_q;

    always_comb begin
        grant    = '0;
        sel_type = '0;
        if (can_take) begin
            if (nmi_pend_q) begin
                grant[GNT_NMI] = 1'b1;
                sel_type       = TYPE_W'(NMI_TYPE);
            end else if (sw_req) begin
                grant[GNT_SW] = 1'b1;
                sel_type      = sw_type;
            end else if (intr_in && if_flag) begin
                grant[GNT_INTR] = 1'b1;
                sel_type        = intr_type;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_in;
            nmi_pend_q <= nmi_rise | (nmi_pend_q & ~grant[GNT_NMI]);
        end
    end

endmodule

// File: rtl/irq_addr_gen.sv
module irq_addr_gen #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int TYPE_W = 8
) (
    input  logic [DATA_W-1:0] seg,
    input  logic [DATA_W-1:0] off,
    input  logic [TYPE_W-1:0] vtype,
    input  logic              sel_vec,
    input  logic              vec_hi,
    output logic [ADDR_W-1:0] addr
);

    localparam int SEG_SHIFT  = ADDR_W - DATA_W;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int VEC_PAD    = ADDR_W - TYPE_W - 2;

    logic [ADDR_W-1:0] stack_addr;
    logic [ADDR_W-1:0] vec_base;

    // segment shifted up by SEG_SHIFT plus zero-extended offset, wraps at ADDR_W
    assign stack_addr = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
    // each vector entry is two words: type * 4
    assign vec_base   = {{VEC_PAD{1'b0}}, vtype, 2'b00};

    always_comb begin
        if (sel_vec) begin
            addr = vec_base + (vec_hi ? ADDR_W'(WORD_BYTES) : '0);
        end else begin
            addr = stack_addr;
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 20,
    parameter int TYPE_W   = 8,
    parameter int NMI_TYPE = 2,
    parameter int IF_POS   = 9,
    parameter int TF_POS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_boundary,
    input  logic              nmi_in,
    input  logic              intr_in,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic              sw_req,
    input  logic [TYPE_W-1:0] sw_type,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [DATA_W-1:0] cs_in,
    input  logic [DATA_W-1:0] ip_in,
    input  logic [DATA_W-1:0] ss_in,
    input  logic [DATA_W-1:0] sp_in,
    output logic [GNT_W-1:0]  src_grant,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] flags_out,
    output logic [DATA_W-1:0] cs_out,
    output logic [DATA_W-1:0] ip_out,
    output logic [DATA_W-1:0] sp_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam logic [DATA_W-1:0] SP_STEP = DATA_W'(WORD_BYTES);

    seq_state_e        state_q, state_d;
    logic [DATA_W-1:0] flags_q, cs_q, ip_q, ss_q, sp_q;
    logic [TYPE_W-1:0] type_q;
    logic [TYPE_W-1:0] sel_type;
    logic              nmi_pend;
    logic              can_take;
    logic              start;
    logic              use_vec;
    logic              vec_hi;

    assign can_take = (state_q == ST_IDLE) && at_boundary;
    assign start    = |src_grant;

    irq_src_arb #(
        .TYPE_W   (TYPE_W),
        .NMI_TYPE (NMI_TYPE)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_in    (nmi_in),
        .intr_in   (intr_in),
        .intr_type (intr_type),
        .sw_req    (sw_req),
        .sw_type   (sw_type),
        .if_flag   (flags_in[IF_POS]),
        .can_take  (can_take),
        .grant     (src_grant),
        .sel_type  (sel_type),
        .nmi_pend  (nmi_pend)
    );

    irq_addr_gen #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .TYPE_W (TYPE_W)
    ) u_addr (
        .seg     (ss_q),
        .off     (sp_q),
        .vtype   (type_q),
        .sel_vec (use_vec),
        .vec_hi  (vec_hi),
        .addr    (mem_addr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)   state_d = ST_PUSH_FL;
            ST_PUSH_FL: if (mem_ack) state_d = ST_CLR_IF;
            ST_CLR_IF:               state_d = ST_CLR_TF;
            ST_CLR_TF:               state_d = ST_PUSH_CS;
            ST_PUSH_CS: if (mem_ack) state_d = ST_PUSH_IP;
            ST_PUSH_IP: if (mem_ack) state_d = ST_RD_IP;
            ST_RD_IP:   if (mem_ack) state_d = ST_RD_CS;
            ST_RD_CS:   if (mem_ack) state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working registers: captured context, stack pointer, vector values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            cs_q    <= '0;
            ip_q    <= '0;
            ss_q    <= '0;
            sp_q    <= '0;
            type_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        flags_q <= flags_in;
                        cs_q    <= cs_in;
                        ip_q    <= ip_in;
                        ss_q    <= ss_in;
                        sp_q    <= sp_in - SP_STEP;
                        type_q  <= sel_type;
                    end
                end
                ST_CLR_IF: flags_q[IF_POS] <= 1'b0;
                ST_CLR_TF: begin
                    flags_q[TF_POS] <= 1'b0;
                    sp_q            <= sp_q - SP_STEP;
                end
                ST_PUSH_CS: if (mem_ack) sp_q <= sp_q - SP_STEP;
                ST_RD_IP:   if (mem_ack) ip_q <= mem_rdata;
                ST_RD_CS:   if (mem_ack) cs_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        use_vec   = 1'b0;
        vec_hi    = 1'b0;
        busy      = (state_q != ST_IDLE);
        done      = 1'b0;
        unique case (state_q)
            ST_PUSH_FL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = flags_q;
            end
            ST_PUSH_CS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = cs_q;
            end
            ST_PUSH_IP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ip_q;
            end
            ST_RD_IP: begin
                mem_req = 1'b1;
                use_vec = 1'b1;
            end
            ST_RD_CS: begin
                mem_req = 1'b1;
                use_vec = 1'b1;
                vec_hi  = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign flags_out = flags_q;
    assign cs_out    = cs_q;
    assign ip_out    = ip_q;
    assign sp_out    = sp_q;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
    import irq_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int IF_POS = 9,
    parameter int TF_POS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_e        state,
    input logic              start,
    input logic              nmi_pend,
    input logic [GNT_W-1:0]  src_grant,
    input logic [DATA_W-1:0] flags_in,
    input logic [DATA_W-1:0] flags_out,
    input logic [DATA_W-1:0] sp_in,
    input logic [DATA_W-1:0] sp_out,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_grant));

    // R2
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_grant[GNT_INTR] |-> !nmi_pend);

    // R3
    intr_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_grant[GNT_INTR] |-> flags_in[IF_POS]);

    // R5
    first_push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> sp_out == $past(sp_in) - 16'd2);

    // R6
    if_before_tf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLR_TF) |-> !flags_out[IF_POS]);

    // R6
    tf_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_CS) |-> !flags_out[TF_POS]);

    // R7
    vec_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr < 20'h00400) && !mem_addr[0]);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IF_POS (IF_POS),
    .TF_POS (TF_POS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .start     (start),
    .nmi_pend  (nmi_pend),
    .src_grant (src_grant),
    .flags_in  (flags_in),
    .flags_out (flags_out),
    .sp_in     (sp_in),
    .sp_out    (sp_out),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;

    typedef struct {
        logic        we;
        logic [19:0] addr;
        logic [15:0] data;
    } bus_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        at_boundary = 1'b1;
    logic        nmi_in = 1'b0;
    logic        intr_in = 1'b0;
    logic [7:0]  intr_type = '0;
    logic        sw_req = 1'b0;
    logic [7:0]  sw_type = '0;
    logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
    logic [2:0]  src_grant;
    logic        busy, done;
    logic [15:0] flags_out, cs_out, ip_out, sp_out;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int mem_delay = 0;
    int wait_cnt = 0;
    logic [19:0] first_addr = '0;
    logic [15:0] memory [logic [19:0]];
    bus_item_t   exp_q [$];

    always #2.5 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary),
        .nmi_in(nmi_in), .intr_in(intr_in), .intr_type(intr_type),
        .sw_req(sw_req), .sw_type(sw_type),
        .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
        .src_grant(src_grant), .busy(busy), .done(done),
        .flags_out(flags_out), .cs_out(cs_out), .ip_out(ip_out), .sp_out(sp_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    // memory model and scoreboard monitor (R5, R7, R9, R10)
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) first_addr = mem_addr;
            if (wait_cnt >= mem_delay) begin
                wait_cnt = 0;
                check(mem_addr == first_addr, "R9 address held", mem_addr, first_addr);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected request", mem_addr, 0);
                end else begin
                    bus_item_t it;
                    it = exp_q.pop_front();
                    check(mem_we == it.we && mem_addr == it.addr, "R5/R7/R10 request order",
                          {11'h0, mem_we, mem_addr}, {11'h0, it.we, it.addr});
                    if (it.we) check(mem_wdata == it.data, "R5 write data", mem_wdata, it.data);
                end
                if (mem_we) memory[mem_addr] = mem_wdata;
                else mem_rdata = memory.exists(mem_addr) ? memory[mem_addr] : 16'hDEAD;
                mem_ack = 1'b1;
            end else begin
                wait_cnt++;
            end
        end
    end

    // driver: one full entry sequence with expected bus items queued
    task automatic serve(input logic [2:0] exp_gnt, input logic [7:0] vtype,
                         input logic [15:0] fl, input logic [15:0] cs, input logic [15:0] ip,
                         input logic [15:0] ss, input logic [15:0] sp, input string tag);
        logic [15:0] ipv, csv;
        logic [19:0] vb;
        int n;
        ipv = 16'h1000 ^ {vtype, 8'h5A};
        csv = 16'h8000 + {8'h0, vtype};
        vb  = {10'h0, vtype, 2'b00};
        memory[vb] = ipv;
        memory[vb + 20'd2] = csv;
        flags_in = fl; cs_in = cs; ip_in = ip; ss_in = ss; sp_in = sp;
        exp_q.push_back('{1'b1, phys(ss, sp - 16'd2), fl});
        exp_q.push_back('{1'b1, phys(ss, sp - 16'd4), cs});
        exp_q.push_back('{1'b1, phys(ss, sp - 16'd6), ip});
        exp_q.push_back('{1'b0, vb, 16'h0});
        exp_q.push_back('{1'b0, vb + 20'd2, 16'h0});
        #1;
        n = 0;
        while (src_grant == 3'b000 && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(src_grant == exp_gnt, {"R2 grant ", tag}, src_grant, exp_gnt);
        @(negedge clk);
        if (exp_gnt == 3'b010) sw_req = 1'b0;
        if (exp_gnt == 3'b100) intr_in = 1'b0;
        n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(done, {"R8 done ", tag}, done, 1);
        check(ip_out == ipv, {"R8 ip ", tag}, ip_out, ipv);
        check(cs_out == csv, {"R8 cs ", tag}, cs_out, csv);
        check(sp_out == sp - 16'd6, {"R5 sp ", tag}, sp_out, sp - 16'd6);
        check(flags_out == (fl & ~16'h0300), {"R6 flags ", tag}, flags_out, fl & ~16'h0300);
        check(exp_q.size() == 0, {"R5 items left ", tag}, exp_q.size(), 0);
        @(negedge clk);
        check(!done, {"R8 pulse ", tag}, done, 0);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        bit quiet = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (src_grant != 3'b000 || busy) quiet = 1'b0;
        end
        check(quiet, req, {31'h0, busy}, 0);
    endtask

    initial begin : watchdog
        #750000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !mem_req && src_grant == 3'b000, "R1 idle outputs",
              {busy, done, mem_req, src_grant}, 0);
        check(flags_out == 0 && cs_out == 0 && ip_out == 0 && sp_out == 0, "R1 registers",
              flags_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // maskable request, IF and TF set
        intr_in = 1'b1; intr_type = 8'h21;
        serve(3'b100, 8'h21, 16'h0382, 16'h348A, 16'h4214, 16'h0A00, 16'h0100, "intr");

        // R3 masked request ignored
        flags_in = 16'h0002; intr_in = 1'b1; intr_type = 8'h40;
        expect_quiet(10, "R3 masked intr ignored");
        intr_in = 1'b0;
        @(negedge clk);

        // R2 all three at once: NMI, then software, then maskable
        at_boundary = 1'b0;
        nmi_in = 1'b1; sw_req = 1'b1; sw_type = 8'h03; intr_in = 1'b1; intr_type = 8'h50;
        flags_in = 16'h0200;
        repeat (2) @(negedge clk);
        at_boundary = 1'b1;
        serve(3'b001, 8'h02, 16'h0200, 16'h1111, 16'h2222, 16'h2000, 16'h0800, "nmi");
        serve(3'b010, 8'h03, 16'h0300, 16'h3333, 16'h4444, 16'h2000, 16'h0800, "sw");
        mem_delay = 2;
        serve(3'b100, 8'h50, 16'h0201, 16'h5555, 16'h6666, 16'h2000, 16'h0800, "intr2");

        // R4 held NMI level does not retrigger
        expect_quiet(10, "R4 held nmi level");
        nmi_in = 1'b0;
        @(negedge clk);

        // R4 edge arriving mid-sequence; R7 top vector with wait states
        mem_delay = 3;
        sw_req = 1'b1; sw_type = 8'hFF;
        fork
            serve(3'b010, 8'hFF, 16'h0000, 16'hABCD, 16'h0123, 16'h1000, 16'h0040, "sw_ff");
            begin
                repeat (5) @(negedge clk);
                nmi_in = 1'b1;
                @(negedge clk);
                nmi_in = 1'b0;
            end
        join
        serve(3'b001, 8'h02, 16'h0300, 16'h0F0F, 16'hF0F0, 16'h1000, 16'h0040, "nmi_late");

        // R10 stack wrap, vector type 0
        mem_delay = 1;
        intr_in = 1'b1; intr_type = 8'h00;
        serve(3'b100, 8'h00, 16'h0200, 16'h7777, 16'h8888, 16'hFFFF, 16'h0004, "wrap");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule